// File: doc/BRIEF.md
# Masked Address Centrifuge Translator

This block turns a remote-access request into a network destination and a global virtual address. A request carries a pointer that picks one of a set of stored base/mask pairs, and a wide address index. The mask marks which index bits name the target processing element (PE). These bits may sit anywhere in the index. The block gathers them into a virtual PE number and squeezes the remaining bits together into an offset. The offset is added to the stored base. The segment field of that sum selects a 64-entry segment table, which yields a global segment and a base PE. The base PE plus the virtual PE gives a logical PE, and a PE table maps the logical PE to a routing tag.

Base, mask, segment and PE entries are written through a single configuration port. One request is in flight at a time. The controller has three states:
- `ST_IDLE` accepts a request (`ST_IDLE -> ST_LOOKUP` on `in_valid`).
- `ST_LOOKUP` performs the table reads (`ST_LOOKUP -> ST_HOLD` always).
- `ST_HOLD` presents the result until it is taken (`ST_HOLD -> ST_IDLE` on `out_ready`).

An invalid segment, a segment sum that overflows, or a logical PE beyond the table all raise a fault in place of a routing tag.

Top module: `addr_centrifuge_xlate`

## Requirements
- R1: Reset puts the block in `ST_IDLE` with `in_ready`=1 and `out_valid`=0, and clears every segment valid bit, so that a request made before any segment write faults.
- R2: `in_ready` is high only in `ST_IDLE`. A request accepted on a rising edge makes `out_valid` high from the second following edge. `in_ready` stays low until the edge on which `out_valid` and `out_ready` are both high, after which the block is idle again.
- R3: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_fault`, `out_tag` and `out_gva` hold their values.
- R4: The virtual PE number is made of the index bits at positions where the mask is 1, packed upward from bit 0 in order of rising source position.
- R5: The offset is made of the index bits at positions where the mask is 0, packed the same way. The sum is offset + base, computed one bit wider than the index. Sum bits [31:0] are the segment offset and sum bits [37:32] are the virtual segment; a carry out of bit 31 moves the request to the next segment.
- R6: On a result without fault, `out_gva` = {global segment (6 bits, bits [37:32]), segment offset (bits [31:0])}.
- R7: Logical PE = base PE from the segment entry + virtual PE. `out_tag` is the PE table entry at that logical PE.
- R8: A segment entry with its valid bit 0 gives `out_fault`=1, with `out_tag`=0 and `out_gva`=0.
- R9: A logical PE >= `PE_ENTRIES` gives a fault (tag and gva 0). A logical PE of `PE_ENTRIES`-1 is translated normally.
- R10: Any nonzero sum bit above bit 37, including the carry bit, gives a fault (tag and gva 0).
- R11: Configuration target codes are: 0 writes the base of block `cfg_index`; 1 writes its mask; 2 writes segment entry `cfg_index`, with data bit [PE_W+6] the valid bit, [PE_W+5:PE_W] the global segment and [PE_W-1:0] the base PE; 3 writes PE entry `cfg_index` from data [TAG_W-1:0]. Segment writes with index >= 64 and PE writes with index >= `PE_ENTRIES` change no entry.
- R12: `in_ptr` chooses which base/mask pair is applied, so the same index under two pointers translates independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_target | input | 2 | Table selected for the write (codes in R11) |
| cfg_index | input | PTR_W | Entry index of the write |
| cfg_data | input | IDX_W | Write data |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_ptr | input | PTR_W | Base/mask block pointer |
| in_index | input | IDX_W | Address index to translate |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_fault | output | 1 | Translation failed |
| out_tag | output | TAG_W | Physical routing tag |
| out_gva | output | 38 | Global segment and segment offset |

## Verification
Masks are tried in several shapes:
- An empty mask, where the offset must equal the index.
- A contiguous low field, which exercises the base PE sum and its table edge.
- Bits scattered across the low and high index, where a lost order or a wrong packing shows up in both the PE number and the offset.

A base that carries across bit 31 separates a correct segment field from one that is taken before the add. Two pointers are applied to one index to show that the base/mask pair is selected per request. Writes with indices just past each table, followed by lookups of entry 0, separate a range-checked write from one that aliases onto entry 0.

// File: rtl/act_pkg.sv
package act_pkg;
    localparam int SEG_OFF_W = 32;
    localparam int GSEG_W    = 6;
    localparam int VSEG_W    = 6;
    localparam int GVA_W     = GSEG_W + SEG_OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_HOLD   = 2'd2
    } xl_state_e;

    typedef enum logic [1:0] {
        CFG_BASE = 2'd0,
        CFG_MASK = 2'd1,
        CFG_SEG  = 2'd2,
        CFG_PE   = 2'd3
    } cfg_tgt_e;
endpackage

// File: rtl/act_centrifuge.sv
module act_centrifuge #(
    parameter int W = 50
) (
    input  logic [W-1:0] idx_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] pe_o,
    output logic [W-1:0] off_o
);
    always_comb begin
        int n_pe;
        int n_off;
        pe_o  = '0;
        off_o = '0;
        n_pe  = 0;
        n_off = 0;
        for (int i = 0; i < W; i++) begin
            if (mask_i[i]) begin
                pe_o[n_pe] = idx_i[i];
                n_pe = n_pe + 1;
            end else begin
                off_o[n_off] = idx_i[i];
                n_off = n_off + 1;
            end
        end
    end
endmodule

// File: rtl/act_seg_table.sv
module act_seg_table #(
    parameter int ENTRIES = 64,
    parameter int GS_W    = 6,
    parameter int BPE_W   = 11,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic             wr_valid,
    input  logic [GS_W-1:0]  wr_gseg,
    input  logic [BPE_W-1:0] wr_bpe,
    input  logic [AW-1:0]    rd_addr,
    output logic             rd_valid,
    output logic [GS_W-1:0]  rd_gseg,
    output logic [BPE_W-1:0] rd_bpe
);
    logic [ENTRIES-1:0] valid_q;
    logic [GS_W-1:0]    gseg_mem [ENTRIES];
    logic [BPE_W-1:0]   bpe_mem  [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_addr] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            gseg_mem[wr_addr] <= wr_gseg;
            bpe_mem[wr_addr]  <= wr_bpe;
        end
    end

    assign rd_valid = valid_q[rd_addr];
    assign rd_gseg  = gseg_mem[rd_addr];
    assign rd_bpe   = bpe_mem[rd_addr];
endmodule

// File: rtl/act_pe_table.sv
module act_pe_table #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 16,
    localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [AW-1:0]    rd_addr,
    output logic [TAG_W-1:0] rd_tag
);
    logic [TAG_W-1:0] tag_mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_addr] <= wr_tag;
        end
    end

    assign rd_tag = tag_mem[rd_addr];
endmodule

// File: rtl/addr_centrifuge_xlate.sv
module addr_centrifuge_xlate
    import act_pkg::*;
#(
    parameter int IDX_W      = 50,
    parameter int PTR_W      = 8,
    parameter int PE_W       = 11,
    parameter int PE_ENTRIES = 64,
    parameter int TAG_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_target,
    input  logic [PTR_W-1:0] cfg_index,
    input  logic [IDX_W-1:0] cfg_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PTR_W-1:0] in_ptr,
    input  logic [IDX_W-1:0] in_index,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_fault,
    output logic [TAG_W-1:0] out_tag,
    output logic [GVA_W-1:0] out_gva
);
    localparam int BLOCKS      = 2 ** PTR_W;
    localparam int SUM_W       = IDX_W + 1;
    localparam int SEG_ENTRIES = 2 ** VSEG_W;
    localparam int PE_AW       = (PE_ENTRIES > 1) ? $clog2(PE_ENTRIES) : 1;
    localparam int VSEG_LO     = SEG_OFF_W;
    localparam int VSEG_HI     = SEG_OFF_W + VSEG_W - 1;
    localparam int SEG_V_BIT   = PE_W + GSEG_W;
    localparam logic [SUM_W-1:0] PE_LIMIT  = SUM_W'(PE_ENTRIES);
    localparam logic [PTR_W-1:0] SEG_LIMIT = PTR_W'(SEG_ENTRIES);
    localparam logic [PTR_W:0]   PEW_LIMIT = (PTR_W + 1)'(PE_ENTRIES);

    xl_state_e state_q, state_d;

    logic [IDX_W-1:0] base_mem [BLOCKS];
    logic [IDX_W-1:0] mask_mem [BLOCKS];
    logic [IDX_W-1:0] sel_base, sel_mask;
    logic [IDX_W-1:0] gath_pe, gath_off;
    logic [IDX_W-1:0] vpe_q;
    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] logical_pe;
    logic             accept, seg_we, pe_we, fault_d;
    logic             seg_v;
    logic [GSEG_W-1:0] seg_gseg;
    logic [PE_W-1:0]  seg_bpe;
    logic [TAG_W-1:0] pe_tag;

    // configuration decode
    assign seg_we = cfg_we && (cfg_target == CFG_SEG) && (cfg_index < SEG_LIMIT);
    assign pe_we  = cfg_we && (cfg_target == CFG_PE) && ({1'b0, cfg_index} < PEW_LIMIT);

    always_ff @(posedge clk) begin
        if (cfg_we && cfg_target == CFG_BASE) begin
            base_mem[cfg_index] <= cfg_data;
        end
        if (cfg_we && cfg_target == CFG_MASK) begin
            mask_mem[cfg_index] <= cfg_data;
        end
    end

    assign sel_base = base_mem[in_ptr];
    assign sel_mask = mask_mem[in_ptr];

    act_centrifuge #(.W(IDX_W)) u_cfg_gather (
        .idx_i (in_index),
        .mask_i(sel_mask),
        .pe_o  (gath_pe),
        .off_o (gath_off)
    );

    act_seg_table #(
        .ENTRIES(SEG_ENTRIES),
        .GS_W   (GSEG_W),
        .BPE_W  (PE_W)
    ) u_seg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_we),
        .wr_addr (cfg_index[VSEG_W-1:0]),
        .wr_valid(cfg_data[SEG_V_BIT]),
        .wr_gseg (cfg_data[SEG_V_BIT-1:PE_W]),
        .wr_bpe  (cfg_data[PE_W-1:0]),
        .rd_addr (sum_q[VSEG_HI:VSEG_LO]),
        .rd_valid(seg_v),
        .rd_gseg (seg_gseg),
        .rd_bpe  (seg_bpe)
    );

    act_pe_table #(
        .ENTRIES(PE_ENTRIES),
        .TAG_W  (TAG_W)
    ) u_pe (
        .clk    (clk),
        .wr_en  (pe_we),
        .wr_addr(cfg_index[PE_AW-1:0]),
        .wr_tag (cfg_data[TAG_W-1:0]),
        .rd_addr(logical_pe[PE_AW-1:0]),
        .rd_tag (pe_tag)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = ST_HOLD;
            ST_HOLD:   if (out_ready) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // handshake outputs
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_HOLD);
    end

    assign accept = in_valid && in_ready;

    // stage 1: gather and add, captured on accept
    always_ff @(posedge clk) begin
        if (accept) begin
            vpe_q <= gath_pe;
            sum_q <= SUM_W'(gath_off) + SUM_W'(sel_base);
        end
    end

    // stage 2: segment and PE mapping
    assign logical_pe = SUM_W'(vpe_q) + SUM_W'(seg_bpe);
    assign fault_d    = !seg_v
                     || (|sum_q[SUM_W-1:VSEG_HI+1])
                     || (logical_pe >= PE_LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_fault <= 1'b0;
            out_tag   <= '0;
            out_gva   <= '0;
        end else if (state_q == ST_LOOKUP) begin
            out_fault <= fault_d;
            out_tag   <= fault_d ? '0 : pe_tag;
            out_gva   <= fault_d ? '0 : {seg_gseg, sum_q[SEG_OFF_W-1:0]};
        end
    end
endmodule

// File: rtl/addr_centrifuge_xlate_chk.sv
module addr_centrifuge_xlate_chk #(
    parameter int TAG_W = 16,
    parameter int GVA_W = 38
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_fault,
    input logic [TAG_W-1:0] out_tag,
    input logic [GVA_W-1:0] out_gva
);
    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (in_ready && !out_valid)); // R1
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R2
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ##2 out_valid); // R2
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && in_ready)); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag)
                                       && $stable(out_gva) && $stable(out_fault))); // R3
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault) |-> (out_tag == '0 && out_gva == '0)); // R8
endmodule

bind addr_centrifuge_xlate addr_centrifuge_xlate_chk #(
    .TAG_W(TAG_W),
    .GVA_W(act_pkg::GVA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_fault(out_fault),
    .out_tag  (out_tag),
    .out_gva  (out_gva)
);

// File: tb/addr_centrifuge_xlate_tb.sv
module addr_centrifuge_xlate_tb;
    localparam int IDX_W = 50;
    localparam int PTR_W = 8;
    localparam int PE_W = 11;
    localparam int PE_ENTRIES = 64;
    localparam int TAG_W = 16;
    localparam int GVA_W = 38;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_target = '0;
    logic [PTR_W-1:0] cfg_index = '0;
    logic [IDX_W-1:0] cfg_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [PTR_W-1:0] in_ptr = '0;
    logic [IDX_W-1:0] in_index = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic             out_fault;
    logic [TAG_W-1:0] out_tag;
    logic [GVA_W-1:0] out_gva;

    always #4 clk = ~clk;

    addr_centrifuge_xlate #(
        .IDX_W(IDX_W), .PTR_W(PTR_W), .PE_W(PE_W),
        .PE_ENTRIES(PE_ENTRIES), .TAG_W(TAG_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_target(cfg_target), .cfg_index(cfg_index), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_ptr(in_ptr), .in_index(in_index),
        .out_valid(out_valid), .out_ready(out_ready), .out_fault(out_fault),
        .out_tag(out_tag), .out_gva(out_gva)
    );

    // reference state
    logic [IDX_W-1:0] m_base [256];
    logic [IDX_W-1:0] m_mask [256];
    bit               m_sv   [64];
    logic [5:0]       m_gseg [64];
    int               m_bpe  [64];
    logic [TAG_W-1:0] m_tag  [64];

    int               phase = 0;
    bit               e_fault;
    logic [TAG_W-1:0] e_tag;
    logic [GVA_W-1:0] e_gva;
    string            e_req = "R2";
    string            cur_req = "R2";
    int               n_chk = 0;
    int               n_bad = 0;
    bit               done = 0;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic void predict(input int ptr, input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] msk;
        logic [IDX_W-1:0] vpe;
        logic [IDX_W-1:0] off;
        logic [IDX_W:0]   sum;
        int np;
        int no;
        int vs;
        longint lpe;
        msk = m_mask[ptr];
        vpe = '0;
        off = '0;
        np = 0;
        no = 0;
        for (int i = 0; i < IDX_W; i++) begin
            if (msk[i]) begin vpe[np] = idx[i]; np++; end
            else begin off[no] = idx[i]; no++; end
        end
        sum = {1'b0, off} + {1'b0, m_base[ptr]};
        vs = int'(sum[37:32]);
        lpe = longint'(vpe) + longint'(m_bpe[vs]);
        e_fault = !m_sv[vs] || (sum[IDX_W:38] != '0) || (lpe >= PE_ENTRIES);
        if (e_fault) begin
            e_tag = '0;
            e_gva = '0;
        end else begin
            e_tag = m_tag[lpe];
            e_gva = {m_gseg[vs], sum[31:0]};
        end
    endfunction

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            phase = 0;
            for (int i = 0; i < 64; i++) m_sv[i] = 1'b0;
        end else begin
            case (phase)
                0: if (in_valid) begin
                    predict(int'(in_ptr), in_index);
                    e_req = cur_req;
                    phase = 1;
                end
                1: phase = 2;
                default: if (out_ready) phase = 0;
            endcase
            if (cfg_we) begin
                case (cfg_target)
                    2'd0: m_base[cfg_index] = cfg_data;
                    2'd1: m_mask[cfg_index] = cfg_data;
                    2'd2: if (cfg_index < 64) begin
                        m_sv[cfg_index]   = cfg_data[PE_W+6];
                        m_gseg[cfg_index] = cfg_data[PE_W+5:PE_W];
                        m_bpe[cfg_index]  = int'(cfg_data[PE_W-1:0]);
                    end
                    default: if (cfg_index < PE_ENTRIES) m_tag[cfg_index] = cfg_data[TAG_W-1:0];
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 in_ready", 64'(in_ready), 64'(phase == 0));
            chk("R2 out_valid", 64'(out_valid), 64'(phase == 2));
            if (phase == 2) begin
                chk({e_req, " fault"}, 64'(out_fault), 64'(e_fault));
                chk({e_req, " tag"}, 64'(out_tag), 64'(e_tag));
                chk({e_req, " gva"}, 64'(out_gva), 64'(e_gva));
            end
        end
    end

    task automatic cfg(input logic [1:0] t, input int ix, input logic [IDX_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_target = t; cfg_index = PTR_W'(ix); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [IDX_W-1:0] seg_word(input bit v, input int g, input int b);
        return IDX_W'({v, 6'(g), 11'(b)});
    endfunction

    task automatic send(input string req, input int ptr, input logic [IDX_W-1:0] idx);
        @(negedge clk);
        cur_req = req; in_valid = 1'b1; in_ptr = PTR_W'(ptr); in_index = idx;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung run expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin m_base[i] = '0; m_mask[i] = '0; end
        for (int i = 0; i < 64; i++) begin m_gseg[i] = '0; m_bpe[i] = 0; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R1 in_ready", 64'(in_ready), 64'd1);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        rst_n = 1'b1;

        // R1: segment valid bits cleared by reset
        cfg(2'd0, 0, '0);
        cfg(2'd1, 0, '0);
        send("R1", 0, 50'h5);

        // tables (R11 layout)
        for (int i = 0; i < 8; i++) cfg(2'd2, i, seg_word(1'b1, 32 + i, 4 * i));
        cfg(2'd2, 9, seg_word(1'b0, 9, 1));
        for (int i = 0; i < PE_ENTRIES; i++) cfg(2'd3, i, IDX_W'(16'hA000 + i * 16'h0103));

        // R4: scattered mask bits 3,7,12,40
        cfg(2'd0, 1, '0);
        cfg(2'd1, 1, 50'h100_0000_1088);
        send("R4", 1, 50'h100_0000_1088);
        send("R4", 1, 50'h80);
        send("R4", 1, 50'h1000);
        send("R4", 1, 50'h0_0005_5A5F);

        // R12: same index under another pointer
        cfg(2'd0, 200, 50'h1_0000_0000);
        cfg(2'd1, 200, 50'h3);
        send("R12", 1, 50'h1089);
        send("R12", 200, 50'h1089);

        // R5: carry across bit 31 into the segment field
        cfg(2'd0, 2, 50'h3_0000_0010);
        cfg(2'd1, 2, '0);
        send("R5", 2, 50'h0_FFFF_FFF5);

        // R6, R7: low PE field, offset into the gva
        cfg(2'd0, 3, 50'h6_0000_0000);
        cfg(2'd1, 3, 50'hF);
        send("R6", 3, 50'hD_EADB_EEFA);
        send("R7", 3, 50'hF);

        // R9: PE table edge
        cfg(2'd0, 4, 50'h7_0000_0000);
        cfg(2'd1, 4, 50'h3F);
        send("R9", 4, 50'd35);
        send("R9", 4, 50'd36);
        send("R9", 4, 50'h3F);

        // R8: invalid segment entry
        cfg(2'd0, 5, 50'h9_0000_0000);
        cfg(2'd1, 5, '0);
        send("R8", 5, 50'h44);

        // R10: sum beyond the segment field
        cfg(2'd0, 6, 50'h40_0000_0000);
        cfg(2'd1, 6, '0);
        send("R10", 6, 50'h1);

        // R11: out-of-range writes must not alias onto entry 0
        cfg(2'd3, 64, 50'hFFFF);
        cfg(2'd2, 64, seg_word(1'b0, 63, 0));
        cfg(2'd0, 7, '0);
        cfg(2'd1, 7, '0);
        send("R11", 7, 50'h0);

        // R3: back-pressure holds the result
        @(negedge clk);
        out_ready = 1'b0;
        cur_req = "R3"; in_valid = 1'b1; in_ptr = 8'd3; in_index = 50'h1234_5673;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        out_ready = 1'b1;
        repeat (3) @(negedge clk);

        finish_run();
    end
endmodule